// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block keeps the tag and state side of a set-associative cache. Each way of each set holds a valid flag, a line tag, a two-bit access permission and a lock owner (a lock flag plus a requester context number). The data array, the coherence controller and any statistics live elsewhere. The controller issues one command per cycle on the request port and gets the outcome on the response port one cycle later. The outcome is a hit flag, an error flag, the way involved and, for a victim probe, the full line address to evict.

Lookups qualify a tag match by the line's permission. A line whose permission is not-present behaves as absent, and a store to a read-only line misses. A per-set age tracker orders the ways by recency. It is updated on allocation and on every access check whose tag matches, even when the permission then refuses the access. A victim probe names the oldest way. Locks are cleared whenever a line is allocated, deallocated or has its permission changed.

Top module: `tagdir_top`

## Requirements
- R1: A request accepted in cycle N (req_valid high) produces rsp_valid high with its results in cycle N+1. A cycle with no request gives rsp_valid low and all response fields zero. Command codes: 0 idle, 1 access check, 2 presence test, 3 availability test, 4 allocate, 5 deallocate, 6 victim probe, 7 permission change, 8 set lock, 9 clear lock, 10 test lock. Codes 0 and 11-15 return all-zero fields.
- R2: The low OFF_W = log2(BLOCK_BYTES) address bits are ignored. The next SET_W bits select the set, where the number of sets is CACHE_BYTES / BLOCK_BYTES / WAYS and SET_W is its log2. The remaining upper bits form the tag.
- R3: Permission codes are not-present=0, invalid=1, read-only=2, read-write=3. Request kinds are load=0, instruction fetch=1, and store for 2 and 3. An access check hits only when the matching line is read-write, or is read-only and the kind is 0 or 1. rsp_way gives the matched way whenever a tag match exists.
- R4: A line counts as present only if it is valid, its tag matches and its permission is not 0. A presence test returns rsp_hit for such a line and the matching way in rsp_way.
- R5: The availability test hits when the address is present in its set, or when some way of the set is empty or has permission 0.
- R6: A successful allocation writes the lowest-numbered way that is empty or has permission 0. It sets the permission to 1 (invalid) and leaves the line unlocked. The response has rsp_hit=1 and rsp_way set to that way.
- R7: Allocating an address that is already present, or into a set with no free way, returns rsp_err=1 and changes no state.
- R8: Deallocating a present line empties its way and clears its lock. Deallocating an absent address returns rsp_err=1.
- R9: A permission change on a present line writes req_perm and clears the lock. Writing permission 0 makes the line absent. A permission change on an absent address returns rsp_err=1.
- R10: Setting a lock stores req_ctx in a present line, and clearing a lock unlocks it. The lock test hits only when the line is locked with a context equal to req_ctx. Any of these three commands on an absent address returns rsp_err=1.
- R11: The age order of a set is touched by allocation and by an access check with a tag match, whatever the permission outcome. The victim is the least recently touched way. After reset, way 0 is the most recent and way WAYS-1 is the oldest.
- R12: When the set has no free way and the address is absent, a victim probe returns rsp_hit=1, the victim way, and rsp_victim set to that line's address with zero offset bits. Otherwise it returns rsp_err=1 and rsp_victim=0.
- R13: After reset every way is empty and unlocked, and the response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present this cycle |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Byte address of the line |
| req_kind | input | 2 | Request kind for access checks |
| req_perm | input | 2 | New permission for permission change |
| req_ctx | input | CTX_W | Requester context for lock commands |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_hit | output | 1 | Hit or success flag |
| rsp_err | output | 1 | Illegal command for the current state |
| rsp_way | output | WAY_W | Way involved in the command |
| rsp_victim | output | ADDR_W | Line address chosen by a victim probe |

## Verification
A wrong tag, valid flag or permission in one way shows up as a changed rsp_hit or rsp_way on the next command that looks up that line, one cycle after the request. A stale lock shows up on the next lock test. A corrupted age order stays hidden until the set is full; the next victim probe then reports a different way and line address. The bench therefore fills sets, reorders them with matched and refused accesses, and probes after each change, so that age errors reach the ports within a few commands.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

  typedef enum logic [1:0] {
    PERM_NP  = 2'd0,
    PERM_INV = 2'd1,
    PERM_RO  = 2'd2,
    PERM_RW  = 2'd3
  } perm_e;

  typedef enum logic [3:0] {
    CMD_IDLE    = 4'd0,
    CMD_ACCESS  = 4'd1,
    CMD_PRESENT = 4'd2,
    CMD_AVAIL   = 4'd3,
    CMD_ALLOC   = 4'd4,
    CMD_DEALLOC = 4'd5,
    CMD_PROBE   = 4'd6,
    CMD_SETPERM = 4'd7,
    CMD_LOCK    = 4'd8,
    CMD_UNLOCK  = 4'd9,
    CMD_TSTLOCK = 4'd10
  } cmd_e;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_FETCH = 2'd1;

  // Permission grants the request kind: full rights, or read rights for reads.
  function automatic logic perm_grants(input perm_e p, input logic [1:0] kind);
    return (p == PERM_RW) ||
           ((p == PERM_RO) && ((kind == KIND_LOAD) || (kind == KIND_FETCH)));
  endfunction

endpackage

// File: rtl/tagdir_way_match.sv
module tagdir_way_match
  import tagdir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 9,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  row_valid,
  input  logic [TAG_W-1:0] row_tag [WAYS],
  input  perm_e            row_perm [WAYS],
  input  logic [TAG_W-1:0] req_tag,
  output logic [WAYS-1:0]  match_vec,
  output logic [WAYS-1:0]  free_vec,
  output logic             hit_any,
  output logic [WAY_W-1:0] hit_way,
  output logic             free_any,
  output logic [WAY_W-1:0] free_way
);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign match_vec[g] = row_valid[g] && (row_tag[g] == req_tag) && (row_perm[g] != PERM_NP);
    assign free_vec[g]  = !row_valid[g] || (row_perm[g] == PERM_NP);
  end

  assign hit_any  = |match_vec;
  assign free_any = |free_vec;

  // Lowest index wins: scan from the top so later assignments override.
  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way  = WAY_W'(w);
      if (free_vec[w])  free_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way
);

  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  // age 0 = most recently touched, WAYS-1 = victim; ages form a permutation.
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[query_set][w] == OLDEST) victim_way = WAY_W'(w);
  end

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
  import tagdir_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int CACHE_BYTES = 512,
  parameter int WAYS        = 4,
  parameter int CTX_W       = 4,
  localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_perm,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_err,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [ADDR_W-1:0] rsp_victim
);

  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int LINES = CACHE_BYTES / BLOCK_BYTES;
  localparam int SETS  = LINES / WAYS;
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;

  // ---- address arithmetic ----
  function automatic logic [SET_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] f_line_addr(input logic [TAG_W-1:0] t,
                                                    input logic [SET_W-1:0] s);
    return {t, s, {OFF_W{1'b0}}};
  endfunction

  // ---- state ----
  logic              valid_q [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  perm_e             perm_q  [SETS][WAYS];
  logic              lk_q    [SETS][WAYS];
  logic [CTX_W-1:0]  ctx_q   [SETS][WAYS];

  // ---- request decode ----
  cmd_e             cmd;
  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic             unused_off_bits;

  assign cmd             = cmd_e'(req_cmd);
  assign req_set         = f_set(req_addr);
  assign req_tag         = f_tag(req_addr);
  assign unused_off_bits = ^req_addr[OFF_W-1:0];

  // ---- selected set row ----
  logic [WAYS-1:0]  row_valid;
  logic [TAG_W-1:0] row_tag  [WAYS];
  perm_e            row_perm [WAYS];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      row_valid[w] = valid_q[req_set][w];
      row_tag[w]   = tag_q[req_set][w];
      row_perm[w]  = perm_q[req_set][w];
    end
  end

  // ---- named internal events (also used by the checker) ----
  logic [WAYS-1:0]  match_vec, free_vec;
  logic             hit_any, free_any, avail;
  logic [WAY_W-1:0] hit_way, free_way, victim_way;
  perm_e            hit_perm;
  logic             hit_locked;
  logic [CTX_W-1:0] hit_ctx;
  logic             ev_alloc_ok, ev_dealloc, ev_setperm, ev_lock_set, ev_lock_clr;
  logic             ev_touch, ev_probe_ok;
  logic [WAY_W-1:0] touch_way;

  tagdir_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .row_valid (row_valid),
    .row_tag   (row_tag),
    .row_perm  (row_perm),
    .req_tag   (req_tag),
    .match_vec (match_vec),
    .free_vec  (free_vec),
    .hit_any   (hit_any),
    .hit_way   (hit_way),
    .free_any  (free_any),
    .free_way  (free_way)
  );

  tagdir_lru #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_en   (ev_touch),
    .touch_set  (req_set),
    .touch_way  (touch_way),
    .query_set  (req_set),
    .victim_way (victim_way)
  );

  assign avail      = hit_any || free_any;
  assign hit_perm   = hit_any ? row_perm[hit_way] : PERM_NP;
  assign hit_locked = lk_q[req_set][hit_way];
  assign hit_ctx    = ctx_q[req_set][hit_way];

  // ---- command evaluation ----
  logic              nxt_hit, nxt_err;
  logic [WAY_W-1:0]  nxt_way;
  logic [ADDR_W-1:0] nxt_victim;

  always_comb begin
    nxt_hit     = 1'b0;
    nxt_err     = 1'b0;
    nxt_way     = '0;
    nxt_victim  = '0;
    ev_alloc_ok = 1'b0;
    ev_dealloc  = 1'b0;
    ev_setperm  = 1'b0;
    ev_lock_set = 1'b0;
    ev_lock_clr = 1'b0;
    ev_touch    = 1'b0;
    ev_probe_ok = 1'b0;
    touch_way   = hit_way;
    if (req_valid) begin
      unique case (cmd)
        CMD_ACCESS: begin
          nxt_hit  = hit_any && perm_grants(hit_perm, req_kind);
          nxt_way  = hit_any ? hit_way : '0;
          ev_touch = hit_any;
        end
        CMD_PRESENT: begin
          nxt_hit = hit_any;
          nxt_way = hit_any ? hit_way : '0;
        end
        CMD_AVAIL: nxt_hit = avail;
        CMD_ALLOC: begin
          if (!hit_any && free_any) begin
            ev_alloc_ok = 1'b1;
            ev_touch    = 1'b1;
            touch_way   = free_way;
            nxt_hit     = 1'b1;
            nxt_way     = free_way;
          end else begin
            nxt_err = 1'b1;
          end
        end
        CMD_PROBE: begin
          if (!avail) begin
            ev_probe_ok = 1'b1;
            nxt_hit     = 1'b1;
            nxt_way     = victim_way;
            nxt_victim  = f_line_addr(row_tag[victim_way], req_set);
          end else begin
            nxt_err = 1'b1;
          end
        end
        CMD_DEALLOC, CMD_SETPERM, CMD_LOCK, CMD_UNLOCK: begin
          nxt_err = !hit_any;
          nxt_hit = hit_any;
          nxt_way = hit_any ? hit_way : '0;
          ev_dealloc  = hit_any && (cmd == CMD_DEALLOC);
          ev_setperm  = hit_any && (cmd == CMD_SETPERM);
          ev_lock_set = hit_any && (cmd == CMD_LOCK);
          ev_lock_clr = hit_any && (cmd == CMD_UNLOCK);
        end
        CMD_TSTLOCK: begin
          nxt_err = !hit_any;
          nxt_hit = hit_any && hit_locked && (hit_ctx == req_ctx);
          nxt_way = hit_any ? hit_way : '0;
        end
        default: ;
      endcase
    end
  end

  // ---- state update ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          perm_q[s][w]  <= PERM_NP;
          lk_q[s][w]    <= 1'b0;
          ctx_q[s][w]   <= '0;
        end
    end else begin
      if (ev_alloc_ok) begin
        valid_q[req_set][free_way] <= 1'b1;
        tag_q[req_set][free_way]   <= req_tag;
        perm_q[req_set][free_way]  <= PERM_INV;
        lk_q[req_set][free_way]    <= 1'b0;
        ctx_q[req_set][free_way]   <= '0;
      end
      if (ev_dealloc) begin
        valid_q[req_set][hit_way] <= 1'b0;
        perm_q[req_set][hit_way]  <= PERM_NP;
        lk_q[req_set][hit_way]    <= 1'b0;
      end
      if (ev_setperm) begin
        perm_q[req_set][hit_way] <= perm_e'(req_perm);
        lk_q[req_set][hit_way]   <= 1'b0;
      end
      if (ev_lock_set) begin
        lk_q[req_set][hit_way]  <= 1'b1;
        ctx_q[req_set][hit_way] <= req_ctx;
      end
      if (ev_lock_clr) lk_q[req_set][hit_way] <= 1'b0;
    end
  end

  // ---- response register ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_way    <= '0;
      rsp_victim <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= nxt_hit;
      rsp_err    <= nxt_err;
      rsp_way    <= nxt_way;
      rsp_victim <= nxt_victim;
    end
  end

endmodule

// File: rtl/tagdir_checker.sv
module tagdir_checker
  import tagdir_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [3:0]       req_cmd,
  input logic [1:0]       req_kind,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_err,
  input logic [WAYS-1:0]  match_vec,
  input logic [WAYS-1:0]  free_vec,
  input perm_e            hit_perm,
  input logic             ev_alloc_ok,
  input logic [WAY_W-1:0] free_way
);

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // Duplicate live tags in a set would mean allocation let a present line in twice.
  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_store_ro_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd1 && req_kind[1] && (|match_vec) && hit_perm == PERM_RO)
    |=> !rsp_hit);

  assert_alloc_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd4 && ((|match_vec) || !(|free_vec))) |=> rsp_err);

  assert_alloc_into_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc_ok |-> free_vec[free_way]);

  assert_probe_needs_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 4'd6 && ((|free_vec) || (|match_vec))) |=> (rsp_err && !rsp_hit));

endmodule

bind tagdir_top tagdir_checker #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_cmd     (req_cmd),
  .req_kind    (req_kind),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_err     (rsp_err),
  .match_vec   (match_vec),
  .free_vec    (free_vec),
  .hit_perm    (hit_perm),
  .ev_alloc_ok (ev_alloc_ok),
  .free_way    (free_way)
);

// File: tb/tb_tagdir_top.sv
`timescale 1ns/1ps
module tb_tagdir_top;

  localparam int C_ACC = 1, C_PRS = 2, C_AVL = 3, C_ALC = 4, C_DEA = 5;
  localparam int C_PRB = 6, C_SPM = 7, C_LCK = 8, C_ULK = 9, C_TLK = 10;
  localparam int NW = 4, NS = 8;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [3:0]  req_cmd = 0;
  logic [15:0] req_addr = 0;
  logic [1:0]  req_kind = 0, req_perm = 0;
  logic [3:0]  req_ctx = 0;
  logic        rsp_valid, rsp_hit, rsp_err;
  logic [1:0]  rsp_way;
  logic [15:0] rsp_victim;

  tagdir_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm), .req_ctx(req_ctx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
    .rsp_way(rsp_way), .rsp_victim(rsp_victim)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: line address per way, recency list with MRU at position 0
  bit          m_v   [NS][NW];
  logic [11:0] m_ln  [NS][NW];
  int          m_p   [NS][NW];
  bit          m_lk  [NS][NW];
  int          m_ctx [NS][NW];
  int          m_ord [NS][NW];

  bit          q_hit [$];
  bit          q_err [$];
  int          q_way [$];
  logic [15:0] q_vic [$];
  string       q_tag [$];

  task automatic check(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic touch(int s, int w);
    int p = 0;
    for (int i = 0; i < NW; i++) if (m_ord[s][i] == w) p = i;
    for (int i = p; i > 0; i--) m_ord[s][i] = m_ord[s][i-1];
    m_ord[s][0] = w;
  endtask

  function automatic logic [15:0] mk(int tag, int set, int off);
    return 16'((tag << 7) | (set << 4) | off);
  endfunction

  task automatic send(int cmd, logic [15:0] a, int kind, int perm, int ctx, string rq);
    int s = int'(a[6:4]);
    logic [11:0] ln = a[15:4];
    int mi = -1, fi = -1, ew = 0;
    bit eh = 0, ee = 0;
    logic [15:0] ev = 0;
    @(negedge clk); #1;
    for (int w = 0; w < NW; w++) begin
      if (mi < 0 && m_v[s][w] && m_ln[s][w] == ln && m_p[s][w] != 0) mi = w;
      if (fi < 0 && (!m_v[s][w] || m_p[s][w] == 0)) fi = w;
    end
    case (cmd)
      C_ACC: if (mi >= 0) begin
        ew = mi; touch(s, mi);
        eh = (m_p[s][mi] == 3) || (m_p[s][mi] == 2 && kind < 2);
      end
      C_PRS: begin eh = (mi >= 0); ew = (mi >= 0) ? mi : 0; end
      C_AVL: eh = (mi >= 0) || (fi >= 0);
      C_ALC: if (mi < 0 && fi >= 0) begin
        m_v[s][fi] = 1; m_ln[s][fi] = ln; m_p[s][fi] = 1; m_lk[s][fi] = 0; m_ctx[s][fi] = 0;
        touch(s, fi); eh = 1; ew = fi;
      end else ee = 1;
      C_PRB: if (mi < 0 && fi < 0) begin
        ew = m_ord[s][NW-1]; eh = 1; ev = {m_ln[s][ew], 4'h0};
      end else ee = 1;
      C_DEA, C_SPM, C_LCK, C_ULK: if (mi >= 0) begin
        eh = 1; ew = mi;
        if (cmd == C_DEA) begin m_v[s][mi] = 0; m_p[s][mi] = 0; m_lk[s][mi] = 0; end
        if (cmd == C_SPM) begin m_p[s][mi] = perm; m_lk[s][mi] = 0; end
        if (cmd == C_LCK) begin m_lk[s][mi] = 1; m_ctx[s][mi] = ctx; end
        if (cmd == C_ULK) m_lk[s][mi] = 0;
      end else ee = 1;
      C_TLK: if (mi >= 0) begin
        ew = mi; eh = m_lk[s][mi] && (m_ctx[s][mi] == ctx);
      end else ee = 1;
      default: ;
    endcase
    req_valid = 1; req_cmd = 4'(cmd); req_addr = a;
    req_kind = 2'(kind); req_perm = 2'(perm); req_ctx = 4'(ctx);
    q_hit.push_back(eh); q_err.push_back(ee); q_way.push_back(ew);
    q_vic.push_back(ev); q_tag.push_back(rq);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      req_valid = 0; req_cmd = 0;
    end
  endtask

  // monitor: response for a request driven just after negedge k appears by negedge k+1
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_hit.size() > 0) begin
        string rq;
        rq = q_tag.pop_front();
        check("R1", "rsp_valid", int'(rsp_valid), 1);
        check(rq, "rsp_hit", int'(rsp_hit), int'(q_hit.pop_front()));
        check(rq, "rsp_err", int'(rsp_err), int'(q_err.pop_front()));
        check(rq, "rsp_way", int'(rsp_way), q_way.pop_front());
        check(rq, "rsp_victim", int'(rsp_victim), int'(q_vic.pop_front()));
      end else if (rsp_valid) begin
        check("R1", "unexpected rsp_valid", 1, 0);
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_v[s][w] = 0; m_ln[s][w] = 0; m_p[s][w] = 0;
        m_lk[s][w] = 0; m_ctx[s][w] = 0; m_ord[s][w] = w;
      end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R13", "reset rsp_valid", int'(rsp_valid), 0);
    check("R13", "reset rsp_hit", int'(rsp_hit), 0);
    check("R13", "reset rsp_victim", int'(rsp_victim), 0);

    // R13: every set empty after reset
    for (int s = 0; s < NS; s++) send(C_AVL, mk(3, s, 0), 0, 0, 0, "R13");
    send(C_PRS, mk(1, 0, 0), 0, 0, 0, "R4");
    send(C_PRB, mk(1, 0, 0), 0, 0, 0, "R12");

    // R6/R7: allocate and duplicate rejection
    send(C_ALC, mk(1, 0, 0), 0, 0, 0, "R6");
    send(C_ALC, mk(1, 0, 5), 0, 0, 0, "R7");
    send(C_PRS, mk(1, 0, 9), 0, 0, 0, "R2");
    send(C_PRS, mk(1, 1, 0), 0, 0, 0, "R2");
    send(C_ACC, mk(1, 0, 0), 0, 0, 0, "R3");

    // R3: permission against kind
    send(C_SPM, mk(1, 0, 0), 0, 2, 0, "R9");
    send(C_ACC, mk(1, 0, 0), 0, 0, 0, "R3");
    send(C_ACC, mk(1, 0, 0), 1, 0, 0, "R3");
    send(C_ACC, mk(1, 0, 0), 2, 0, 0, "R3");
    send(C_ACC, mk(1, 0, 0), 3, 0, 0, "R3");
    send(C_SPM, mk(1, 0, 0), 0, 3, 0, "R9");
    send(C_ACC, mk(1, 0, 0), 2, 0, 0, "R3");

    // R10 and lock clearing in R9/R8/R6
    send(C_LCK, mk(1, 0, 0), 0, 0, 5, "R10");
    send(C_TLK, mk(1, 0, 0), 0, 0, 5, "R10");
    send(C_TLK, mk(1, 0, 0), 0, 0, 6, "R10");
    send(C_SPM, mk(1, 0, 0), 0, 3, 0, "R9");
    send(C_TLK, mk(1, 0, 0), 0, 0, 5, "R9");
    send(C_LCK, mk(1, 0, 0), 0, 0, 7, "R10");
    send(C_ULK, mk(1, 0, 0), 0, 0, 0, "R10");
    send(C_TLK, mk(1, 0, 0), 0, 0, 7, "R10");
    send(C_LCK, mk(1, 0, 0), 0, 0, 7, "R10");
    send(C_DEA, mk(1, 0, 0), 0, 0, 0, "R8");
    send(C_DEA, mk(1, 0, 0), 0, 0, 0, "R8");
    send(C_TLK, mk(1, 0, 0), 0, 0, 7, "R10");
    send(C_LCK, mk(9, 0, 0), 0, 0, 1, "R10");
    send(C_ALC, mk(1, 0, 0), 0, 0, 0, "R6");
    send(C_TLK, mk(1, 0, 0), 0, 0, 7, "R6");

    // fill set 0, then victim and age ordering
    send(C_ALC, mk(2, 0, 0), 0, 0, 0, "R6");
    send(C_ALC, mk(3, 0, 0), 0, 0, 0, "R6");
    send(C_ALC, mk(4, 0, 0), 0, 0, 0, "R6");
    send(C_AVL, mk(5, 0, 0), 0, 0, 0, "R5");
    send(C_AVL, mk(3, 0, 0), 0, 0, 0, "R5");
    send(C_ALC, mk(5, 0, 0), 0, 0, 0, "R7");
    send(C_PRB, mk(5, 0, 0), 0, 0, 0, "R12");
    send(C_PRB, mk(2, 0, 0), 0, 0, 0, "R12");
    send(C_ACC, mk(1, 0, 0), 2, 0, 0, "R11");
    send(C_PRB, mk(5, 0, 0), 0, 0, 0, "R11");
    send(C_ACC, mk(2, 0, 0), 0, 0, 0, "R11");
    send(C_PRB, mk(5, 0, 0), 0, 0, 0, "R11");
    send(C_PRS, mk(3, 0, 0), 0, 0, 0, "R11");
    send(C_PRB, mk(5, 0, 0), 0, 0, 0, "R11");
    idle(2);

    // permission 0 frees a way; allocation takes the lowest free way
    send(C_SPM, mk(2, 0, 0), 0, 0, 0, "R9");
    send(C_PRS, mk(2, 0, 0), 0, 0, 0, "R4");
    send(C_ACC, mk(2, 0, 0), 0, 0, 0, "R4");
    send(C_AVL, mk(5, 0, 0), 0, 0, 0, "R5");
    send(C_SPM, mk(2, 0, 0), 0, 3, 0, "R9");
    send(C_DEA, mk(4, 0, 0), 0, 0, 0, "R8");
    send(C_ALC, mk(5, 0, 0), 0, 0, 0, "R6");
    send(C_ALC, mk(6, 0, 0), 0, 0, 0, "R6");
    send(C_PRB, mk(7, 0, 0), 0, 0, 0, "R12");
    send(15, mk(1, 0, 0), 0, 0, 0, "R1");

    // broad pseudo-random mix over a few sets and tags
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      int c, t, st, k, p, x;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      c  = 1 + (int'(lf[3:0]) % 10);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      t  = int'(lf[2:0]) % 6;
      st = int'(lf[3]);
      k  = int'(lf[5:4]);
      p  = int'(lf[7:6]);
      x  = int'(lf[9:8]);
      if (c == C_SPM && p == 0 && lf[10]) p = 3;
      send(c, mk(t, st, int'(lf[14:11])), k, p, x, "R11");
      if (lf[15] && lf[0]) idle(1);
    end
    idle(3);
    check("R1", "outstanding responses", q_hit.size(), 0);

    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule